// File: doc/BRIEF.md
# Asymmetric Dual-Issue Pairing Logic

This block sits at the end of decode in an in-order, two-wide processor front end. Each cycle it looks at the two oldest decoded instructions: an older slot and a younger slot. Each slot carries a valid bit and a pre-classified group code. The block decides whether the older instruction issues, and whether the younger one can issue beside it. It also steers every issuing instruction to one of four execution pipes: integer, load/store, branch or floating-point execute. The pipes are not identical, so pairing is decided by group. Each group owns one resource. A flexible transfer group may take either the integer pipe or the load/store pipe. A serialising group always goes out alone.

The decision is purely combinational and is summarised in a three-valued verdict. HOLD means nothing issues. This happens when the downstream ready is low or the older slot is empty. SOLO means only the older instruction issues. The younger one then moves up to the older position in the next cycle, which the feeding queue handles. DUAL means both instructions issue. The verdict is taken on every evaluation directly from the inputs: HOLD when issue is blocked, otherwise DUAL when the pairing rules allow it, otherwise SOLO. The block keeps no memory between cycles, so no verdict depends on the one before it. The steering stage selects its pipe assignment by verdict.

Top module: `dual_issue_pair`

## Requirements
- R1: Group codes on the 3-bit inputs are integer=0, load/store=1, branch=2, flexible transfer=3, FP execute=4, serialising=5; codes 6 and 7 behave exactly as serialising.
- R2: When `rdy_i` is low or `old_vld_i` is low, neither fire output is asserted and both pipe outputs are all-zero.
- R3: When `rdy_i` and `old_vld_i` are high, `old_fire_o` is asserted whatever the groups; a low `yng_vld_i` leaves the older instruction issuing alone.
- R4: `yng_fire_o` is asserted only when `old_fire_o` is asserted, `yng_vld_i` is high and the pairing rules allow the pair.
- R5: Two instructions of the same group never issue together, except two flexible-transfer instructions.
- R6: A serialising instruction in either slot never issues together with another instruction.
- R7: Branch pairs with integer, load/store, flexible transfer and FP execute; FP execute pairs with integer, load/store, branch and flexible transfer.
- R8: A flexible-transfer instruction goes to load/store when paired with integer, to integer when paired with load/store, and to integer in every other case. When two flexible transfers pair, the older goes to integer and the younger to load/store.
- R9: Pipe outputs are one-hot with bit 0 integer, bit 1 load/store, bit 2 branch, bit 3 FP execute. A fixed group uses its own pipe. Serialising reports integer. A slot that does not fire reports all-zero. Two issuing instructions never share a pipe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rdy_i | input | 1 | Downstream pipes can accept instructions this cycle |
| old_vld_i | input | 1 | Older slot holds an instruction |
| old_grp_i | input | 3 | Group code of the older instruction |
| yng_vld_i | input | 1 | Younger slot holds an instruction |
| yng_grp_i | input | 3 | Group code of the younger instruction |
| old_fire_o | output | 1 | Older instruction issues |
| yng_fire_o | output | 1 | Younger instruction issues alongside the older |
| old_pipe_o | output | 4 | One-hot pipe of the older instruction |
| yng_pipe_o | output | 4 | One-hot pipe of the younger instruction |

## Verification
The block holds no state, so a wrong verdict or steering choice shows at the ports in the same cycle as the input pattern that causes it. A verdict stuck at SOLO shows up as a younger fire that never appears on legal pairs. A verdict stuck at DUAL shows up as same-group or serialising pairs issuing together. A misrouted flexible transfer appears as a pipe bit that collides with its partner's bit or sits on the wrong pipe. The bench applies every combination of ready, valid bits and all eight codes in both slots, and compares each one against an independent model on the next clock edge.

// File: rtl/dip_pkg.sv
package dip_pkg;

    localparam int GRP_W  = 3;
    localparam int PIPE_N = 4;

    // bit positions of the one-hot pipe vector
    localparam int PIPE_INT = 0;
    localparam int PIPE_LS  = 1;
    localparam int PIPE_BR  = 2;
    localparam int PIPE_FE  = 3;

    typedef enum logic [GRP_W-1:0] {
        GRP_INT = 3'd0,
        GRP_LS  = 3'd1,
        GRP_BR  = 3'd2,
        GRP_BO  = 3'd3,
        GRP_FE  = 3'd4,
        GRP_NS  = 3'd5
    } grp_e;

    typedef enum logic [1:0] {
        VERDICT_HOLD = 2'd0,
        VERDICT_SOLO = 2'd1,
        VERDICT_DUAL = 2'd2
    } verdict_e;

    typedef logic [PIPE_N-1:0] pipe_vec_t;

endpackage

// File: rtl/dip_grp_norm.sv
module dip_grp_norm
    import dip_pkg::*;
(
    input  logic [GRP_W-1:0] code_i,
    output grp_e             grp_o
);

    // R1: the two spare codes fold onto the serialising group
    always_comb begin
        if (code_i > GRP_W'(GRP_NS)) begin
            grp_o = GRP_NS;
        end else begin
            grp_o = grp_e'(code_i);
        end
    end

endmodule

// File: rtl/dip_pair_judge.sv
module dip_pair_judge
    import dip_pkg::*;
(
    input  logic     rdy_i,
    input  logic     old_vld_i,
    input  logic     yng_vld_i,
    input  grp_e     old_grp_i,
    input  grp_e     yng_grp_i,
    output verdict_e verdict_o
);

    logic can_issue;
    logic any_ns;
    logic same_grp;
    logic both_bo;
    logic pair_ok;

    always_comb begin
        can_issue = rdy_i && old_vld_i;
        any_ns    = (old_grp_i == GRP_NS) || (yng_grp_i == GRP_NS);
        same_grp  = (old_grp_i == yng_grp_i);
        both_bo   = (old_grp_i == GRP_BO) && (yng_grp_i == GRP_BO);
        pair_ok   = yng_vld_i && !any_ns && (!same_grp || both_bo);
    end

    always_comb begin
        unique case ({can_issue, pair_ok})
            2'b11:   verdict_o = VERDICT_DUAL;
            2'b10:   verdict_o = VERDICT_SOLO;
            default: verdict_o = VERDICT_HOLD;
        endcase
    end

    // R6: a serialising group never yields a paired verdict
    always_comb begin
        if (verdict_o == VERDICT_DUAL) begin
            assert_ns_alone_R6: assert (old_grp_i != GRP_NS && yng_grp_i != GRP_NS)
                else $error("serialising instruction paired");
        end
    end

endmodule

// File: rtl/dip_pipe_steer.sv
module dip_pipe_steer
    import dip_pkg::*;
(
    input  verdict_e  verdict_i,
    input  grp_e      old_grp_i,
    input  grp_e      yng_grp_i,
    output pipe_vec_t old_pipe_o,
    output pipe_vec_t yng_pipe_o
);

    // fixed home pipe of a group; the flexible group defaults to integer
    function automatic pipe_vec_t home_pipe(grp_e g);
        pipe_vec_t v;
        v = '0;
        unique case (g)
            GRP_LS:  v[PIPE_LS]  = 1'b1;
            GRP_BR:  v[PIPE_BR]  = 1'b1;
            GRP_FE:  v[PIPE_FE]  = 1'b1;
            default: v[PIPE_INT] = 1'b1;
        endcase
        return v;
    endfunction

    pipe_vec_t old_dual;
    pipe_vec_t yng_dual;

    // R8: the flexible slot takes whichever of integer / load-store is left
    always_comb begin
        old_dual = home_pipe(old_grp_i);
        if (old_grp_i == GRP_BO && yng_grp_i == GRP_INT) begin
            old_dual = '0;
            old_dual[PIPE_LS] = 1'b1;
        end
        yng_dual = home_pipe(yng_grp_i);
        if (yng_grp_i == GRP_BO && old_dual[PIPE_INT]) begin
            yng_dual = '0;
            yng_dual[PIPE_LS] = 1'b1;
        end
    end

    always_comb begin
        unique case (verdict_i)
            VERDICT_DUAL: begin
                old_pipe_o = old_dual;
                yng_pipe_o = yng_dual;
            end
            VERDICT_SOLO: begin
                old_pipe_o = home_pipe(old_grp_i);
                yng_pipe_o = '0;
            end
            default: begin
                old_pipe_o = '0;
                yng_pipe_o = '0;
            end
        endcase
    end

    // R9: paired instructions never share a pipe
    always_comb begin
        if (verdict_i == VERDICT_DUAL) begin
            assert_no_pipe_clash_R9: assert ((old_pipe_o & yng_pipe_o) == '0)
                else $error("two instructions on one pipe");
        end
    end

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
    import dip_pkg::*;
#(
    parameter int SLOTS = 2
) (
    input  logic             rdy_i,
    input  logic             old_vld_i,
    input  logic [GRP_W-1:0] old_grp_i,
    input  logic             yng_vld_i,
    input  logic [GRP_W-1:0] yng_grp_i,
    output logic             old_fire_o,
    output logic             yng_fire_o,
    output logic [PIPE_N-1:0] old_pipe_o,
    output logic [PIPE_N-1:0] yng_pipe_o
);

    localparam int OLD = 0;
    localparam int YNG = SLOTS - 1;

    logic [SLOTS-1:0][GRP_W-1:0] code_w;
    grp_e                        grp_w [SLOTS];
    verdict_e                    verdict;
    pipe_vec_t                   old_pipe;
    pipe_vec_t                   yng_pipe;

    assign code_w[OLD] = old_grp_i;
    assign code_w[YNG] = yng_grp_i;

    for (genvar s = 0; s < SLOTS; s++) begin : g_norm
        dip_grp_norm u_norm (
            .code_i (code_w[s]),
            .grp_o  (grp_w[s])
        );
    end

    dip_pair_judge u_judge (
        .rdy_i     (rdy_i),
        .old_vld_i (old_vld_i),
        .yng_vld_i (yng_vld_i),
        .old_grp_i (grp_w[OLD]),
        .yng_grp_i (grp_w[YNG]),
        .verdict_o (verdict)
    );

    dip_pipe_steer u_steer (
        .verdict_i  (verdict),
        .old_grp_i  (grp_w[OLD]),
        .yng_grp_i  (grp_w[YNG]),
        .old_pipe_o (old_pipe),
        .yng_pipe_o (yng_pipe)
    );

    always_comb begin
        unique case (verdict)
            VERDICT_DUAL: begin
                old_fire_o = 1'b1;
                yng_fire_o = 1'b1;
            end
            VERDICT_SOLO: begin
                old_fire_o = 1'b1;
                yng_fire_o = 1'b0;
            end
            default: begin
                old_fire_o = 1'b0;
                yng_fire_o = 1'b0;
            end
        endcase
        old_pipe_o = old_pipe;
        yng_pipe_o = yng_pipe;
    end

    always_comb begin
        // R4: in-order issue
        assert_in_order_R4: assert (!yng_fire_o || old_fire_o)
            else $error("younger issued without older");
        // R2: blocked issue
        assert_blocked_R2: assert ((rdy_i && old_vld_i) || (!old_fire_o && !yng_fire_o))
            else $error("issue while blocked");
        // R9: pipe vector matches fire
        assert_old_onehot_R9: assert (old_fire_o ? $onehot(old_pipe_o) : (old_pipe_o == '0))
            else $error("older pipe not one-hot");
        assert_yng_onehot_R9: assert (yng_fire_o ? $onehot(yng_pipe_o) : (yng_pipe_o == '0))
            else $error("younger pipe not one-hot");
        // R5: same raw group cannot pair unless flexible
        assert_same_grp_R5: assert (!(yng_fire_o && old_grp_i == yng_grp_i) || old_grp_i == GRP_W'(GRP_BO))
            else $error("same group paired");
    end

endmodule

// File: tb/dual_issue_pair_tb_top.sv
module dual_issue_pair_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct {
        logic       ofire;
        logic       yfire;
        logic [3:0] opipe;
        logic [3:0] ypipe;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rdy_i = 1'b0;
    logic       old_vld_i = 1'b0;
    logic [2:0] old_grp_i = 3'd0;
    logic       yng_vld_i = 1'b0;
    logic [2:0] yng_grp_i = 3'd0;
    logic       old_fire_o;
    logic       yng_fire_o;
    logic [3:0] old_pipe_o;
    logic [3:0] yng_pipe_o;

    int   n_cmp  = 0;
    int   n_bad  = 0;
    exp_t sb_q[$];
    bit   done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_issue_pair dut_i (
        .rdy_i      (rdy_i),
        .old_vld_i  (old_vld_i),
        .old_grp_i  (old_grp_i),
        .yng_vld_i  (yng_vld_i),
        .yng_grp_i  (yng_grp_i),
        .old_fire_o (old_fire_o),
        .yng_fire_o (yng_fire_o),
        .old_pipe_o (old_pipe_o),
        .yng_pipe_o (yng_pipe_o)
    );

    // pipe index of a fixed group: INT->0, LS->1, BR->2, FE->3, NS->0
    function automatic int fixed_idx(int g);
        case (g)
            1: return 1;
            2: return 2;
            4: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic exp_t model(bit r, bit ov, int og, bit yv, int yg);
        exp_t e;
        int   go, gy, oi, yi;
        bit   pair_ok;
        go = (og > 5) ? 5 : og;
        gy = (yg > 5) ? 5 : yg;
        pair_ok = (go != 5) && (gy != 5) && ((go != gy) || (go == 3));
        e.ofire = r && ov;
        e.yfire = e.ofire && yv && pair_ok;
        oi = (go == 3) ? ((e.yfire && gy == 0) ? 1 : 0) : fixed_idx(go);
        yi = (gy == 3) ? ((oi == 0) ? 1 : 0) : fixed_idx(gy);
        e.opipe = e.ofire ? 4'(1 << oi) : 4'd0;
        e.ypipe = e.yfire ? 4'(1 << yi) : 4'd0;
        if (og > 5 || yg > 5)                    e.tag = "R1";
        else if (!r || !ov)                      e.tag = "R2";
        else if (!yv)                            e.tag = "R3 R4";
        else if (go == 5 || gy == 5)             e.tag = "R6";
        else if (go == gy)                       e.tag = "R5";
        else if (go == 3 || gy == 3)             e.tag = "R8";
        else if (go == 2 || gy == 2 || go == 4 || gy == 4) e.tag = "R7";
        else                                     e.tag = "R9";
        return e;
    endfunction

    // driver: apply one pattern and queue its expected result
    task automatic drive(bit r, bit ov, int og, bit yv, int yg);
        @(negedge clk);
        rdy_i     = r;
        old_vld_i = ov;
        old_grp_i = 3'(og);
        yng_vld_i = yv;
        yng_grp_i = 3'(yg);
        sb_q.push_back(model(r, ov, og, yv, yg));
    endtask

    // monitor: compare on the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                if (old_fire_o !== e.ofire || yng_fire_o !== e.yfire ||
                    old_pipe_o !== e.opipe || yng_pipe_o !== e.ypipe) begin
                    n_bad++;
                    $display("FAIL %s: rdy=%0b ov=%0b og=%0d yv=%0b yg=%0d got fire=%0b%0b pipe=%b/%b exp fire=%0b%0b pipe=%b/%b",
                             e.tag, rdy_i, old_vld_i, old_grp_i, yng_vld_i, yng_grp_i,
                             old_fire_o, yng_fire_o, old_pipe_o, yng_pipe_o,
                             e.ofire, e.yfire, e.opipe, e.ypipe);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // reset: idle inputs give no issue (R2)
        repeat (3) drive(0, 0, 0, 0, 0);
        rst = 1'b0;
        // directed: INT+LS pair on own pipes (R9)
        drive(1, 1, 0, 1, 1);
        // BO+BO: older INT, younger LS (R8)
        drive(1, 1, 3, 1, 3);
        // BO with INT goes LS, with LS goes INT (R8)
        drive(1, 1, 3, 1, 0);
        drive(1, 1, 1, 1, 3);
        // BR+FE pair (R7)
        drive(1, 1, 2, 1, 4);
        // same group blocks pairing (R5)
        drive(1, 1, 4, 1, 4);
        // serialising in younger or older slot (R6)
        drive(1, 1, 0, 1, 5);
        drive(1, 1, 5, 1, 0);
        // spare codes act as serialising (R1)
        drive(1, 1, 7, 1, 1);
        drive(1, 1, 2, 1, 6);
        // ready low blocks everything (R2)
        drive(0, 1, 0, 1, 1);
        // invalid younger: older alone (R3)
        drive(1, 1, 3, 0, 0);
        // exhaustive sweep over all patterns
        for (int r = 0; r < 2; r++)
            for (int ov = 0; ov < 2; ov++)
                for (int og = 0; og < 8; og++)
                    for (int yv = 0; yv < 2; yv++)
                        for (int yg = 0; yg < 8; yg++)
                            drive(r[0], ov[0], og, yv[0], yg);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule